// File: doc/BRIEF.md
# SPI Serial EEPROM Slave Engine

This block is the device side of a byte-addressed serial EEPROM reached over a four-wire SPI link in mode 0. A transaction opens when chip select falls. The first eight bits on the serial input form the instruction. Read and write instructions then take a 16-bit byte address, most significant bit first. The serial inputs are brought into the block clock domain through a parameterised synchronizer. Serial input is sampled on rising serial-clock edges, and the serial output changes on falling edges.

A read streams bytes out most significant bit first. The address advances after every byte and wraps over the whole array. A write is accepted only after the write-enable latch has been set. Each received byte goes to an internal page-programming unit through a byte/address/commit interface, and that unit holds the array. Programming starts when chip select rises on a byte boundary. During the internal write cycle the busy flag is set, and every instruction except the status read is locked out.

Top module: `spi_eeprom_slave`

## Requirements
- R1: After reset the write-enable latch and the busy flag are clear, so a status read returns 0x00, and the output enable is low.
- R2: Instruction 0x03 followed by a 16-bit address returns the addressed byte on `so`, most significant bit first. `so` changes after a falling `sck` edge and `si` is sampled on rising edges. `so_oe` is high only while output bits are being shifted and is low during the instruction and address bits.
- R3: As long as chip select stays low, a read moves to the next address after each byte and wraps from the highest address (0x3FF by default) to 0x000.
- R4: Address bits above the array size are ignored. With 1024 bytes, addresses 0xFC40, 0xA840 and 0x0040 reach the same byte.
- R5: Instruction 0x06 sets the write-enable latch and instruction 0x04 clears it. The latch shows as bit 1 of the status byte.
- R6: A write instruction (0x02) issued while the latch is clear changes no memory byte and starts no internal write cycle.
- R7: An accepted write is committed only when chip select rises after a whole number of data bytes, at least one. A rise in the middle of a byte discards the whole transaction and leaves the latch set.
- R8: Within a write, only the low five address bits advance after each byte, so data wraps inside its 32-byte page.
- R9: Instruction 0x05 returns the status byte {000000, latch, busy}. Bit 0 is 1 for the whole internal write cycle of WR_CYC clocks after a commit, and 0 otherwise.
- R10: While busy, every instruction except the status read is ignored: a read drives no output, and a latch-clear has no effect.
- R11: The write-enable latch clears by itself at the end of an internal write cycle.
- R12: An unknown instruction drives no output and has no effect until chip select rises. A new falling edge is required before another command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; oversamples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the bus master |
| si | input | 1 | Serial data into the device |
| so | output | 1 | Serial data out of the device |
| so_oe | output | 1 | Output enable for the tri-state driver of `so` |

## Verification
A wrong internal state surfaces within one serial byte. A bad address counter or a bad page wrap shows as a wrong byte on the very next read. A stuck write-enable latch or busy flag appears at once in the next status byte. A lockout or rejection that does not work either changes memory, which a later read shows, or raises `so_oe` in a phase where it must stay low, which is seen on the same bit.

// File: rtl/eep_pkg.sv
package eep_pkg;
   localparam int ADDR_BITS = 16;

   localparam logic [7:0] OPC_WREN  = 8'h06;
   localparam logic [7:0] OPC_WRDI  = 8'h04;
   localparam logic [7:0] OPC_RDSR  = 8'h05;
   localparam logic [7:0] OPC_WRSR  = 8'h01;
   localparam logic [7:0] OPC_READ  = 8'h03;
   localparam logic [7:0] OPC_WRITE = 8'h02;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_OP,
      PH_ADDR,
      PH_WDATA,
      PH_OUT,
      PH_SKIP
   } phase_t;
endpackage

// File: rtl/eep_sync.sv
module eep_sync #(
   parameter int              STAGES  = 2,
   parameter int              W       = 3,
   parameter logic [W-1:0]    RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [W-1:0] pipe [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
            end else begin
               pipe[0] <= d;
               for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
            end
         end
         assign q = pipe[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/eep_page_prog.sv
module eep_page_prog #(
   parameter int DEPTH  = 1024,
   parameter int PAGE   = 32,
   parameter int WR_CYC = 256
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     push,
   input  logic [$clog2(DEPTH)-1:0] push_addr,
   input  logic [7:0]               push_data,
   input  logic                     commit,
   input  logic                     abort,
   input  logic [$clog2(DEPTH)-1:0] rd_addr,
   output logic [7:0]               rd_data,
   output logic                     busy,
   output logic                     done
);
   localparam int AW = $clog2(DEPTH);
   localparam int PGW = $clog2(PAGE);
   localparam int CW = $clog2(WR_CYC + 1);

   logic [7:0]      mem      [DEPTH];
   logic [7:0]      buf_data [PAGE];
   logic [PAGE-1:0] buf_vld;
   logic [AW-PGW-1:0] base;
   logic [CW-1:0]   cnt;
   logic [PGW-1:0]  slot;
   logic            wr_now;

   assign slot    = cnt[PGW-1:0];
   assign wr_now  = busy && (cnt < CW'(PAGE)) && buf_vld[slot];
   assign rd_data = mem[rd_addr];

   always_ff @(posedge clk) begin
      if (push) buf_data[push_addr[PGW-1:0]] <= push_data;
      if (wr_now) mem[{base, slot}] <= buf_data[slot];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_vld <= '0;
         base    <= '0;
         busy    <= 1'b0;
         done    <= 1'b0;
         cnt     <= '0;
      end else begin
         done <= 1'b0;
         if (push) begin
            buf_vld[push_addr[PGW-1:0]] <= 1'b1;
            base <= push_addr[AW-1:PGW];
         end
         if (abort) buf_vld <= '0;
         if (commit && !busy && (buf_vld != '0)) begin
            busy <= 1'b1;
            cnt  <= '0;
         end else if (busy) begin
            if (cnt == CW'(WR_CYC - 1)) begin
               busy    <= 1'b0;
               done    <= 1'b1;
               buf_vld <= '0;
            end else begin
               cnt <= cnt + CW'(1);
            end
         end
      end
   end

   a_r10_no_push_busy: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !busy);
   a_r9_busy_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && !busy && buf_vld != '0) |=> busy);
   a_r9_busy_ends_done: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);
endmodule

// File: rtl/eep_cmd_engine.sv
module eep_cmd_engine
   import eep_pkg::*;
#(
   parameter int AW  = 10,
   parameter int PGW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cs_n_s,
   input  logic          sck_s,
   input  logic          si_s,
   input  logic          busy,
   input  logic          wr_done,
   input  logic [7:0]    rd_data,
   output logic [AW-1:0] rd_addr,
   output logic          wr_push,
   output logic [AW-1:0] wr_addr,
   output logic [7:0]    wr_data,
   output logic          wr_commit,
   output logic          wr_abort,
   output logic          so,
   output logic          so_oe
);
   phase_t               phase;
   logic                 sck_q, cs_q;
   logic [3:0]           cnt;
   logic [6:0]           sh;
   logic [ADDR_BITS-1:0] addr;
   logic                 wel, rd_q, rdsr_q, got_byte;
   logic [7:0]           out_byte;
   logic [2:0]           out_bit;
   logic [7:0]           in_byte;
   logic [7:0]           load_byte;
   logic                 sck_rise, sck_fall;

   assign sck_rise  = sck_s && !sck_q;
   assign sck_fall  = !sck_s && sck_q;
   assign in_byte   = {sh, si_s};
   assign load_byte = rdsr_q ? {6'b0, wel, busy} : rd_data;
   assign rd_addr   = addr[AW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE; sck_q <= 1'b0; cs_q <= 1'b1; cnt <= '0; sh <= '0;
         addr <= '0; wel <= 1'b0; rd_q <= 1'b0; rdsr_q <= 1'b0; got_byte <= 1'b0;
         out_byte <= '0; out_bit <= '0; so <= 1'b0; so_oe <= 1'b0;
         wr_push <= 1'b0; wr_addr <= '0; wr_data <= '0;
         wr_commit <= 1'b0; wr_abort <= 1'b0;
      end else begin
         sck_q     <= sck_s;
         cs_q      <= cs_n_s;
         wr_push   <= 1'b0;
         wr_commit <= 1'b0;
         wr_abort  <= 1'b0;
         if (wr_done) wel <= 1'b0;
         if (cs_n_s) begin
            phase <= PH_IDLE;
            so_oe <= 1'b0;
            if (!cs_q && phase == PH_WDATA) begin
               if (cnt == 4'd0 && got_byte) wr_commit <= 1'b1;
               else                         wr_abort  <= 1'b1;
            end
         end else if (cs_q) begin
            phase    <= PH_OP;
            cnt      <= '0;
            got_byte <= 1'b0;
         end else if (sck_rise) begin
            case (phase)
               PH_OP: begin
                  sh  <= in_byte[6:0];
                  cnt <= cnt + 4'd1;
                  if (cnt == 4'd7) begin
                     cnt     <= '0;
                     out_bit <= '0;
                     rdsr_q  <= (in_byte == OPC_RDSR);
                     rd_q    <= (in_byte == OPC_READ);
                     if (busy && in_byte != OPC_RDSR) phase <= PH_SKIP;
                     else begin
                        case (in_byte)
                           OPC_WREN:  begin wel <= 1'b1; phase <= PH_SKIP; end
                           OPC_WRDI:  begin wel <= 1'b0; phase <= PH_SKIP; end
                           OPC_RDSR:  phase <= PH_OUT;
                           OPC_READ:  phase <= PH_ADDR;
                           OPC_WRITE: phase <= wel ? PH_ADDR : PH_SKIP;
                           default:   phase <= PH_SKIP;
                        endcase
                     end
                  end
               end
               PH_ADDR: begin
                  addr <= {addr[ADDR_BITS-2:0], si_s};
                  cnt  <= cnt + 4'd1;
                  if (cnt == 4'd15) begin
                     cnt     <= '0;
                     out_bit <= '0;
                     phase   <= rd_q ? PH_OUT : PH_WDATA;
                  end
               end
               PH_WDATA: begin
                  sh  <= in_byte[6:0];
                  cnt <= cnt + 4'd1;
                  if (cnt == 4'd7) begin
                     cnt      <= '0;
                     wr_push  <= 1'b1;
                     wr_data  <= in_byte;
                     wr_addr  <= addr[AW-1:0];
                     addr     <= {addr[ADDR_BITS-1:PGW], addr[PGW-1:0] + 1'b1};
                     got_byte <= 1'b1;
                  end
               end
               default: ;
            endcase
         end else if (sck_fall && phase == PH_OUT) begin
            so_oe   <= 1'b1;
            out_bit <= out_bit + 3'd1;
            if (out_bit == 3'd0) begin
               so       <= load_byte[7];
               out_byte <= {load_byte[6:0], 1'b0};
               if (!rdsr_q) addr <= addr + 16'd1;
            end else begin
               so       <= out_byte[7];
               out_byte <= {out_byte[6:0], 1'b0};
            end
         end
      end
   end

   a_r2_oe_drops_cs: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n_s |=> !so_oe);
   a_r6_commit_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
      wr_commit |-> wel);
   a_r11_wel_clears: assert property (@(posedge clk) disable iff (!rst_n)
      wr_done |=> !wel);
   a_r12_skip_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_SKIP) |-> !so_oe);
endmodule

// File: rtl/spi_eeprom_slave.sv
module spi_eeprom_slave #(
   parameter int DEPTH       = 1024,
   parameter int PAGE        = 32,
   parameter int WR_CYC      = 256,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n,
   input  logic sck,
   input  logic si,
   output logic so,
   output logic so_oe
);
   localparam int AW  = $clog2(DEPTH);
   localparam int PGW = $clog2(PAGE);

   generate
      if ((1 << AW) != DEPTH || AW > eep_pkg::ADDR_BITS) begin : g_bad_depth
         $error("DEPTH must be a power of two addressable by 16 bits");
      end
      if ((1 << PGW) != PAGE || PAGE >= DEPTH || PAGE < 2) begin : g_bad_page
         $error("PAGE must be a power of two, at least 2, below DEPTH");
      end
      if (WR_CYC < PAGE) begin : g_bad_cyc
         $error("WR_CYC must cover at least one cycle per page byte");
      end
   endgenerate

   logic [2:0]    pins_s;
   logic          busy, done, push, commit, abort;
   logic [AW-1:0] rd_addr, wr_addr;
   logic [7:0]    rd_data, wr_data;

   eep_sync #(.STAGES(SYNC_STAGES), .W(3), .RST_VAL(3'b100)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({cs_n, sck, si}), .q(pins_s));

   eep_cmd_engine #(.AW(AW), .PGW(PGW)) u_engine (
      .clk(clk), .rst_n(rst_n),
      .cs_n_s(pins_s[2]), .sck_s(pins_s[1]), .si_s(pins_s[0]),
      .busy(busy), .wr_done(done), .rd_data(rd_data), .rd_addr(rd_addr),
      .wr_push(push), .wr_addr(wr_addr), .wr_data(wr_data),
      .wr_commit(commit), .wr_abort(abort), .so(so), .so_oe(so_oe));

   eep_page_prog #(.DEPTH(DEPTH), .PAGE(PAGE), .WR_CYC(WR_CYC)) u_prog (
      .clk(clk), .rst_n(rst_n), .push(push), .push_addr(wr_addr),
      .push_data(wr_data), .commit(commit), .abort(abort),
      .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .done(done));
endmodule

// File: tb/spi_eeprom_slave_tb.sv
module spi_eeprom_slave_tb;
   localparam int H   = 8;
   localparam int WRC = 2000;

   logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, si = 1'b0;
   logic so, so_oe;
   int   checks = 0, failures = 0;
   bit   finished = 1'b0;
   logic [7:0] mm [int];
   logic [7:0] rxq [$];

   always #4 clk = ~clk;

   spi_eeprom_slave #(.WR_CYC(WRC)) u_dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
      .so(so), .so_oe(so_oe));

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic bit_io(input logic d, output logic s, output logic oe);
      @(negedge clk) si = d;
      repeat (H) @(negedge clk);
      s = so; oe = so_oe;
      sck = 1'b1;
      repeat (H) @(negedge clk);
      sck = 1'b0;
   endtask

   task automatic send_bits(input logic [7:0] b, input int n, input string req);
      int oe_cnt = 0;
      for (int i = 7; i > 7 - n; i--) begin
         logic s, oe;
         bit_io(b[i], s, oe);
         if (oe) oe_cnt++;
      end
      chk(oe_cnt == 0, req, "so_oe during input bits", oe_cnt, 0);
   endtask

   task automatic recv(output logic [7:0] b, input int exp_oe, input string req);
      int oe_cnt = 0;
      for (int i = 7; i >= 0; i--) begin
         logic s, oe;
         bit_io(1'b0, s, oe);
         b[i] = s;
         if (oe) oe_cnt++;
      end
      chk(oe_cnt == exp_oe, req, "so_oe during output bits", oe_cnt, exp_oe);
   endtask

   task automatic cs_lo();
      @(negedge clk) cs_n = 1'b0;
      repeat (H) @(negedge clk);
   endtask

   task automatic cs_hi();
      repeat (H) @(negedge clk);
      cs_n = 1'b1;
      repeat (3 * H) @(negedge clk);
   endtask

   task automatic cmd(input logic [7:0] op, input string req);
      cs_lo(); send_bits(op, 8, req); cs_hi();
   endtask

   task automatic rdsr(input logic [7:0] exp, input string req);
      logic [7:0] b;
      cs_lo(); send_bits(8'h05, 8, req); recv(b, 8, req); cs_hi();
      chk(b == exp, req, "status byte", b, exp);
   endtask

   task automatic rd(input logic [15:0] a, input int n, input int exp_oe, input string req);
      logic [7:0] b;
      rxq.delete();
      cs_lo();
      send_bits(8'h03, 8, req); send_bits(a[15:8], 8, req); send_bits(a[7:0], 8, req);
      for (int i = 0; i < n; i++) begin
         recv(b, exp_oe, req);
         rxq.push_back(b);
      end
      cs_hi();
   endtask

   task automatic rd_chk(input logic [15:0] a, input int n, input string req);
      rd(a, n, 8, req);
      for (int i = 0; i < n; i++) begin
         int k = (int'(a) + i) & 'h3FF;
         chk(rxq[i] == mm[k], req, $sformatf("read byte @%0h", k), rxq[i], mm[k]);
      end
   endtask

   task automatic wr(input logic [15:0] a, input logic [7:0] d [$], input bit model);
      cs_lo();
      send_bits(8'h02, 8, "R6"); send_bits(a[15:8], 8, "R6"); send_bits(a[7:0], 8, "R6");
      foreach (d[i]) send_bits(d[i], 8, "R8");
      cs_hi();
      if (model)
         foreach (d[i]) mm[(int'(a) & 'h3E0) | ((int'(a) + i) & 'h1F)] = d[i];
   endtask

   task automatic wait_wr();
      repeat (WRC + 100) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++; failures++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      // R1: reset state
      chk(so_oe == 1'b0, "R1", "so_oe after reset", so_oe, 0);
      rdsr(8'h00, "R1");
      // R5: latch set and clear
      cmd(8'h06, "R5"); rdsr(8'h02, "R5");
      cmd(8'h04, "R5"); rdsr(8'h00, "R5");
      // R9, R10, R11: write, busy lockout, auto clear
      cmd(8'h06, "R9");
      wr(16'h0010, '{8'h55}, 1'b1);
      rdsr(8'h03, "R9");
      cmd(8'h04, "R10");
      rdsr(8'h03, "R10");
      rd(16'h0010, 1, 0, "R10");
      wait_wr();
      rdsr(8'h00, "R11");
      rd_chk(16'h0010, 1, "R2");
      // R6: write without the latch
      wr(16'h0010, '{8'hAA}, 1'b0);
      rdsr(8'h00, "R6");
      rd_chk(16'h0010, 1, "R6");
      // R8: page wrap inside a write
      cmd(8'h06, "R8");
      wr(16'h001E, '{8'h11, 8'h22, 8'h33}, 1'b1);
      wait_wr();
      rd_chk(16'h001E, 2, "R8");
      rd_chk(16'h0000, 1, "R8");
      // R3: sequential read wraps at the top of the array
      cmd(8'h06, "R3");
      wr(16'h03FE, '{8'hA1, 8'hA2}, 1'b1);
      wait_wr();
      rd_chk(16'h03FE, 3, "R3");
      // R4: upper address bits ignored
      cmd(8'h06, "R4");
      wr(16'hFC40, '{8'h5A}, 1'b1);
      wait_wr();
      rd_chk(16'h0040, 1, "R4");
      rd_chk(16'hA840, 1, "R4");
      // R7: mid-byte chip-select rise discards the write
      cmd(8'h06, "R7");
      wr(16'h0050, '{8'h66}, 1'b1);
      wait_wr();
      cmd(8'h06, "R7");
      cs_lo();
      send_bits(8'h02, 8, "R7"); send_bits(8'h00, 8, "R7"); send_bits(8'h50, 8, "R7");
      send_bits(8'h77, 8, "R7"); send_bits(8'h99, 4, "R7");
      cs_hi();
      rdsr(8'h02, "R7");
      rd_chk(16'h0050, 1, "R7");
      cmd(8'h04, "R5"); rdsr(8'h00, "R5");
      // R12: unknown instruction stays silent
      begin
         logic [7:0] b;
         cs_lo();
         send_bits(8'hFF, 8, "R12"); send_bits(8'h00, 8, "R12");
         send_bits(8'h06, 8, "R12"); send_bits(8'h03, 8, "R12");
         recv(b, 0, "R12");
         cs_hi();
      end
      rdsr(8'h00, "R12");
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule